// File: doc/BRIEF.md
# 4:1:1 YUV Output Data Formatter

This block sits behind a video converter that produces one luma sample per clock and one chroma pair (U and V) per group of four clocks. Luma leaves the block in parallel on an 8-bit port as plain binary. Each chroma byte is first recoded from offset binary to two's complement. It is then spread over the four output cycles of its group, two bits per cycle, on a 2-bit U port and a 2-bit V port. One U/V pair therefore serves four luma samples.

A horizontal reference input sets the grouping. On every rising edge of the reference, a new group begins with the sample taken on that edge, even if the previous group is not finished. Every sample passes through a fixed four-stage pipeline. The group phase and a chroma-valid flag travel with the sample. The flag stays low until the first reference edge since reset. It is also low for any sample taken with the clamp input high, and for every sample whose group began with the clamp input high.

An active-low drive control stands in for three-state pads. The block reports the pad enable on a separate output and forces the data lines to zero while the pads are released.

Top module: `yuv411_formatter`

## Requirements
- R1: While reset is asserted, y_out, u_out, v_out, grp_phase and chroma_valid are all zero.
- R2: The luma value captured at clock edge k appears unchanged on y_out in the cycle after edge k+3, which is four register stages counting the capture stage.
- R3: Each chroma byte is recoded by inverting its bit 7. An input of 0x80 becomes 0x00, 0x00 becomes 0x80 and 0xFF becomes 0x7F.
- R4: U and V are captured with the phase-0 sample of a group. In output phases 0, 1, 2 and 3, u_out[1] carries bits 7, 5, 3 and 1 of the recoded U byte, and u_out[0] carries bits 6, 4, 2 and 0. v_out does the same for V in the same cycles.
- R5: When no reference edge occurs, successive samples take phases 0, 1, 2, 3, 0, and so on. grp_phase shows the phase of the sample currently on y_out.
- R6: A sample captured on an edge where href is 1, and href was 0 at the previous edge, gets phase 0 and starts a new chroma capture. This holds even when the running group is incomplete.
- R7: When reference edges come a multiple of four clocks apart, the phase sequence continues without a break.
- R8: With drive_n at 1, out_en is 0 and y_out, u_out and v_out are 0. With drive_n at 0, out_en is 1 and the data lines carry pipeline data. Both take effect combinationally.
- R9: chroma_valid is 0 for samples captured before the first reference edge since reset. It is also 0 for samples captured with clamp high, and for samples whose group's phase-0 sample was captured with clamp high. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| y_in | input | 8 | Luma sample, binary |
| u_in | input | 8 | U sample, offset binary, used on phase-0 cycles |
| v_in | input | 8 | V sample, offset binary, used on phase-0 cycles |
| href | input | 1 | Horizontal reference; a rising edge restarts the group |
| clamp | input | 1 | Clamp active; marks chroma invalid |
| drive_n | input | 1 | Active-low pad drive control |
| out_en | output | 1 | Pad enable for all twelve data lines |
| y_out | output | 8 | Luma output |
| u_out | output | 2 | Serialised U bits, two per cycle |
| v_out | output | 2 | Serialised V bits, two per cycle |
| grp_phase | output | 2 | Group phase of the sample on the outputs |
| chroma_valid | output | 1 | Chroma of the current output sample is usable |

## Verification
The bench builds the block with its default values: 8-bit samples, which gives four-cycle groups and 2-bit phases, and a pipeline depth of four. With these defaults the 30-entry stimulus table reaches the following cases:
- reference edges that land exactly on a group boundary;
- a reference edge that cuts a group short after two samples;
- a clamp pulse inside a running group;
- a clamp pulse on a phase-0 sample;
- chroma codes at the two's-complement extremes.

A single-sample luma impulse pins the latency to the exact cycle.

// File: rtl/yuv411_pkg.sv
package yuv411_pkg;
  // Converter word width; chroma goes out two bits per cycle, so a group
  // spans half as many cycles as there are bits.
  localparam int SAMPLE_W  = 8;
  localparam int GROUP_LEN = SAMPLE_W / 2;
  localparam int PH_W      = $clog2(GROUP_LEN);

  // One pipeline slot: everything that travels alongside a luma sample.
  typedef struct packed {
    logic [SAMPLE_W-1:0] y;
    logic [1:0]          u_pair;
    logic [1:0]          v_pair;
    logic [PH_W-1:0]     ph;
    logic                cvalid;
  } slot_t;
endpackage

// File: rtl/yuv411_phase_gen.sv
module yuv411_phase_gen
  import yuv411_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            href,
  output logic [PH_W-1:0] cur_ph,
  output logic            grp_start,
  output logic            synced
);

  localparam logic [PH_W-1:0] PH_LAST = PH_W'(GROUP_LEN - 1);

  logic            href_q, href_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            sync_q, sync_d;
  logic            rise;

  // next state
  always_comb begin
    rise   = href & ~href_q;
    if (rise)
      cur_ph = '0;
    else if (ph_q == PH_LAST)
      cur_ph = '0;
    else
      cur_ph = ph_q + PH_W'(1);
    ph_d      = cur_ph;
    href_d    = href;
    sync_d    = sync_q | rise;
    grp_start = (cur_ph == '0);
    synced    = sync_d;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      href_q <= 1'b0;
      ph_q   <= PH_LAST;
      sync_q <= 1'b0;
    end else begin
      href_q <= href_d;
      ph_q   <= ph_d;
      sync_q <= sync_d;
    end
  end

  // R6: a reference edge forces the captured phase back to zero
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (href && !href_q) |=> (ph_q == '0));

  // R5: without a reference edge the phase steps by one and wraps
  a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!(href && !href_q) && ph_q != PH_LAST) |=> (ph_q == $past(ph_q) + PH_W'(1)));

endmodule

// File: rtl/yuv411_chroma_slicer.sv
module yuv411_chroma_slicer
  import yuv411_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] u_in,
  input  logic [SAMPLE_W-1:0] v_in,
  input  logic                clamp,
  input  logic [PH_W-1:0]     cur_ph,
  input  logic                grp_start,
  input  logic                synced,
  output logic [1:0]          u_pair,
  output logic [1:0]          v_pair,
  output logic                cvalid
);

  logic [SAMPLE_W-1:0] u_hold, u_hold_d;
  logic [SAMPLE_W-1:0] v_hold, v_hold_d;
  logic                gclamp_q, gclamp_d;
  logic [SAMPLE_W-1:0] u_cur, v_cur;
  logic                gclamp_cur;

  // Offset binary to two's complement: flip the top bit.
  function automatic logic [SAMPLE_W-1:0] to_twos(input logic [SAMPLE_W-1:0] b);
    return {~b[SAMPLE_W-1], b[SAMPLE_W-2:0]};
  endfunction

  // Pick the bit pair for a phase: phase 0 takes the two top bits.
  function automatic logic [1:0] pick_pair(input logic [SAMPLE_W-1:0] b,
                                           input logic [PH_W-1:0]     p);
    logic [1:0] r;
    r = '0;
    for (int i = 0; i < GROUP_LEN; i++) begin
      if (p == PH_W'(i)) r = b[SAMPLE_W-1-2*i -: 2];
    end
    return r;
  endfunction

  // next state
  always_comb begin
    u_cur      = grp_start ? to_twos(u_in) : u_hold;
    v_cur      = grp_start ? to_twos(v_in) : v_hold;
    gclamp_cur = grp_start ? clamp : gclamp_q;
    u_hold_d   = u_cur;
    v_hold_d   = v_cur;
    gclamp_d   = gclamp_cur;
    u_pair     = pick_pair(u_cur, cur_ph);
    v_pair     = pick_pair(v_cur, cur_ph);
    cvalid     = synced & ~clamp & ~gclamp_cur;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u_hold   <= '0;
      v_hold   <= '0;
      gclamp_q <= 1'b0;
    end else begin
      u_hold   <= u_hold_d;
      v_hold   <= v_hold_d;
      gclamp_q <= gclamp_d;
    end
  end

  // R4: the held bytes change only on a group start
  a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_start |=> ($stable(u_hold) && $stable(v_hold)));

  // R3: the captured byte has its top bit opposite to the input's
  a_r3_msb_flip: assert property (@(posedge clk) disable iff (!rst_n)
    grp_start |=> (u_hold[SAMPLE_W-1] != $past(u_in[SAMPLE_W-1]) &&
                   v_hold[SAMPLE_W-1] != $past(v_in[SAMPLE_W-1])));

endmodule

// File: rtl/yuv411_delay_line.sv
module yuv411_delay_line
  import yuv411_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  slot_t d,
  output slot_t q
);

  slot_t stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    slot_t stg_d;
    if (i == 0) begin : g_head
      always_comb stg_d = d;
    end else begin : g_body
      always_comb stg_d = stg[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg_d;
    end
  end

  assign q = stg[DEPTH-1];

endmodule

// File: rtl/yuv411_formatter.sv
module yuv411_formatter
  import yuv411_pkg::*;
#(
  parameter int LATENCY     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] y_in,
  input  logic [SAMPLE_W-1:0] u_in,
  input  logic [SAMPLE_W-1:0] v_in,
  input  logic                href,
  input  logic                clamp,
  input  logic                drive_n,
  output logic                out_en,
  output logic [SAMPLE_W-1:0] y_out,
  output logic [1:0]          u_out,
  output logic [1:0]          v_out,
  output logic [PH_W-1:0]     grp_phase,
  output logic                chroma_valid
);

  // Reset: asserted at once, released after SYNC_STAGES clock edges.
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe[SYNC_STAGES-1];

  logic [PH_W-1:0] cur_ph;
  logic            grp_start;
  logic            synced;
  logic [1:0]      u_pair, v_pair;
  logic            cvalid;
  slot_t           slot_in, slot_out;

  yuv411_phase_gen u_phase (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .href      (href),
    .cur_ph    (cur_ph),
    .grp_start (grp_start),
    .synced    (synced)
  );

  yuv411_chroma_slicer u_slice (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .u_in      (u_in),
    .v_in      (v_in),
    .clamp     (clamp),
    .cur_ph    (cur_ph),
    .grp_start (grp_start),
    .synced    (synced),
    .u_pair    (u_pair),
    .v_pair    (v_pair),
    .cvalid    (cvalid)
  );

  always_comb begin
    slot_in.y      = y_in;
    slot_in.u_pair = u_pair;
    slot_in.v_pair = v_pair;
    slot_in.ph     = cur_ph;
    slot_in.cvalid = cvalid;
  end

  yuv411_delay_line #(.DEPTH(LATENCY)) u_pipe (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (slot_in),
    .q     (slot_out)
  );

  // Pad model: an enable plus data held at zero while the pads are released.
  always_comb begin
    out_en       = ~drive_n;
    y_out        = out_en ? slot_out.y      : '0;
    u_out        = out_en ? slot_out.u_pair : '0;
    v_out        = out_en ? slot_out.v_pair : '0;
    grp_phase    = slot_out.ph;
    chroma_valid = slot_out.cvalid;
  end

  // R8: released pads carry no data
  a_r8_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_core_n)
    drive_n |-> (!out_en && y_out == '0 && u_out == '0 && v_out == '0));

endmodule

// File: tb/yuv411_formatter_test.sv
module yuv411_formatter_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] y_in, u_in, v_in;
  logic       href, clamp, drive_n;
  logic       out_en;
  logic [7:0] y_out;
  logic [1:0] u_out, v_out;
  logic [1:0] grp_phase;
  logic       chroma_valid;

  int checks   = 0;
  int failures = 0;

  always #5 clk = ~clk;

  yuv411_formatter uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .y_in         (y_in),
    .u_in         (u_in),
    .v_in         (v_in),
    .href         (href),
    .clamp        (clamp),
    .drive_n      (drive_n),
    .out_en       (out_en),
    .y_out        (y_out),
    .u_out        (u_out),
    .v_out        (v_out),
    .grp_phase    (grp_phase),
    .chroma_valid (chroma_valid)
  );

  // Stimulus table: {href, clamp, expected phase[1:0]}
  localparam int NVEC = 30;
  localparam logic [3:0] VEC [0:NVEC-1] = '{
    4'b1000, 4'b1001, 4'b0010, 4'b0011,   // first reference edge
    4'b1000, 4'b1001, 4'b0010, 4'b0011,   // R7 edge on a boundary
    4'b1000, 4'b0001, 4'b0010, 4'b0011,
    4'b0000, 4'b0001,                     // R5 free-running wrap
    4'b1000, 4'b0001, 4'b0110, 4'b0011,   // R6 cut short, clamp mid-group
    4'b0000, 4'b0001, 4'b0010, 4'b0011,
    4'b1100, 4'b0001, 4'b0010, 4'b0011,   // clamp on a group start
    4'b0000, 4'b0001, 4'b0010, 4'b0011
  };

  // Expected record per capture edge
  logic [7:0] hy [0:255];
  logic [1:0] hu [0:255];
  logic [1:0] hv [0:255];
  logic [1:0] hp [0:255];
  logic       hval [0:255];
  logic       hchk [0:255];
  int         n = 0;

  // Model state
  logic       m_href_q = 1'b0;
  logic       m_sync   = 1'b0;
  int         m_ph     = 3;
  logic [7:0] m_u = '0, m_v = '0;
  logic       m_gc = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One sample: check the record due now, drive, then model the capture.
  task automatic step(input logic h, input logic c, input logic [7:0] y,
                      input logic [7:0] u, input logic [7:0] v,
                      input logic chk, input logic [1:0] eph);
    int r;
    logic rise;
    @(negedge clk);
    r = n - 4;
    if (r >= 0 && hchk[r]) begin
      check("R2", "y_out", 32'(y_out), 32'(hy[r]));
      check("R3,R4", "u_out", 32'(u_out), 32'(hu[r]));
      check("R4", "v_out", 32'(v_out), 32'(hv[r]));
      check("R5/R6/R7", "grp_phase", 32'(grp_phase), 32'(hp[r]));
      check("R9", "chroma_valid", 32'(chroma_valid), 32'(hval[r]));
    end
    href = h; clamp = c; y_in = y; u_in = u; v_in = v;
    @(posedge clk);
    rise     = h && !m_href_q;
    m_href_q = h;
    if (rise) m_sync = 1'b1;
    m_ph = rise ? 0 : (m_ph + 1) % 4;
    if (m_ph == 0) begin
      m_u  = {~u[7], u[6:0]};
      m_v  = {~v[7], v[6:0]};
      m_gc = c;
    end
    hy[n]   = y;
    hu[n]   = {m_u[7-2*m_ph], m_u[6-2*m_ph]};
    hv[n]   = {m_v[7-2*m_ph], m_v[6-2*m_ph]};
    hp[n]   = eph;
    hval[n] = m_sync && !c && !m_gc;
    hchk[n] = chk;
    n++;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; drive_n = 1'b0;
    href = 1'b0; clamp = 1'b0;
    y_in = 8'hC3; u_in = 8'h11; v_in = 8'h22;
    repeat (3) @(negedge clk);
    // R1 reset state, inputs busy
    check("R1", "y_out", 32'(y_out), 32'h0);
    check("R1", "u_out", 32'(u_out), 32'h0);
    check("R1", "v_out", 32'(v_out), 32'h0);
    check("R1", "grp_phase", 32'(grp_phase), 32'h0);
    check("R1", "chroma_valid", 32'(chroma_valid), 32'h0);
    rst_n = 1'b1;

    // Idle before any reference edge: chroma never valid (R9)
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 1'b0, 8'h00, 8'h80, 8'h80, 1'b0, 2'd0);
      check("R9", "unsynced chroma_valid", 32'(chroma_valid), 32'h0);
    end

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] uu, vv;
      uu = (i == 0) ? 8'h80 : (i == 4) ? 8'h00 : (i == 8) ? 8'hFF : 8'(i * 37 + 60);
      vv = 8'(i * 91 + 5);
      step(VEC[i][3], VEC[i][2], 8'(i * 29 + 7), uu, vv, 1'b1, VEC[i][1:0]);
    end
    for (int i = 0; i < 4; i++)
      step(1'b0, 1'b0, 8'h00, 8'h80, 8'h80, 1'b0, 2'd0);

    // R2 impulse: exact output cycle
    @(negedge clk);
    y_in = 8'h5A;
    @(posedge clk);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (k == 0) y_in = 8'h00;
      check("R2", "impulse y_out", 32'(y_out), (k == 3) ? 32'h5A : 32'h0);
      @(posedge clk);
    end

    // R8 pad release and drive
    @(negedge clk);
    y_in = 8'hA5;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R8", "driven out_en", 32'(out_en), 32'h1);
    check("R8", "driven y_out", 32'(y_out), 32'hA5);
    drive_n = 1'b1;
    #1;
    check("R8", "released out_en", 32'(out_en), 32'h0);
    check("R8", "released y_out", 32'(y_out), 32'h0);
    check("R8", "released chroma", 32'({u_out, v_out}), 32'h0);
    drive_n = 1'b0;
    #1;
    check("R8", "redriven out_en", 32'(out_en), 32'h1);
    check("R8", "redriven y_out", 32'(y_out), 32'hA5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule